// File: doc/BRIEF.md
# Receive FIFO Automatic Flow Controller

This block watches how full a receive data FIFO is and slows the far end of the link down when that FIFO gets close to full. It compares the FIFO byte count against a high threshold and a low threshold. Both thresholds are counted in 64-byte units, and the gap between them gives hysteresis.

In full-duplex operation the block asks the MAC for pause frames. It makes one request with the configured pause time when the level reaches the high threshold. It makes a later request with pause time zero when the level falls under the low threshold, but only if the first request was taken.

In half-duplex operation it jams incoming frames instead, using a back-pressure signal. A frame is jammed when it belongs to an enabled class (address match, broadcast or multicast) and arrives while the FIFO is at or above the high threshold. Back pressure lasts for a time chosen by a 4-bit code. With the any-frame enable set, the class decode is skipped and jamming starts on the preamble of the next frame.

Top module: `rx_flow_ctl`

## Requirements
- R1: After reset, `pause_req` and `jam` are both low.
- R2: The FIFO level counts as high when floor(`fifo_bytes`/64) >= `cfg_hi_thr`, and as low when floor(`fifo_bytes`/64) < `cfg_lo_thr`.
- R3: With `full_duplex`=1 and `cfg_en` bit 0 (any-frame) set, `pause_req` rises one clock after the level becomes high. While it is raised, `pause_time` equals `cfg_pause_time`. It stays raised until a one-cycle `pause_ack` is sampled.
- R4: Only one pause request with a nonzero time is made per high crossing. A level that stays high after the acknowledge raises no further request.
- R5: After an acknowledged high request, the first clock with the level low raises `pause_req` with `pause_time`=0, held until `pause_ack`. No zero-time request is made if no high request was acknowledged.
- R6: In full-duplex mode, `cfg_en` bits 1 to 3 have no effect: they raise no pause request, and `jam` stays low.
- R7: In half-duplex mode with `cfg_en` bit 0 clear, a `rx_frame_valid` pulse while the level is high raises `jam` from the next clock for (`cfg_jam_code`+1)*`JAM_UNIT` cycles. The pulse must have a class whose enable is set: `rx_addr_hit` with bit 1, `rx_bcast` with bit 2, or `rx_mcast` with bit 3.
- R8: In half-duplex mode with `cfg_en` bit 0 set, an `rx_preamble` pulse while the level is high starts the same back pressure without any `rx_frame_valid`. In this mode, class matches on `rx_frame_valid` trigger nothing.
- R9: No back pressure starts when the level is not high, or when the frame's class is not enabled.
- R10: While `full_duplex` is low or `cfg_en` bit 0 is clear, any pending request is dropped within one clock and the sent flag is cleared, so no later zero-time request follows.
- R11: In half-duplex mode, `pause_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_bytes | input | LVL_W | Receive FIFO fill level in bytes |
| full_duplex | input | 1 | 1 = full-duplex link, 0 = half-duplex |
| cfg_hi_thr | input | 8 | High threshold, 64-byte units |
| cfg_lo_thr | input | 8 | Low threshold, 64-byte units |
| cfg_jam_code | input | 4 | Back-pressure duration code |
| cfg_en | input | 4 | Enables: bit0 any-frame, bit1 address match, bit2 broadcast, bit3 multicast |
| cfg_pause_time | input | PT_W | Pause time for the high-threshold request |
| rx_preamble | input | 1 | One-cycle pulse: valid preamble seen |
| rx_frame_valid | input | 1 | One-cycle pulse: address decode of the current frame done |
| rx_addr_hit | input | 1 | Frame addressed to this station (valid with rx_frame_valid) |
| rx_bcast | input | 1 | Frame is broadcast (valid with rx_frame_valid) |
| rx_mcast | input | 1 | Frame is multicast (valid with rx_frame_valid) |
| pause_ack | input | 1 | One-cycle pulse: MAC accepted the pending pause request |
| pause_req | output | 1 | Pause frame request, held until acknowledged |
| pause_time | output | PT_W | Pause time of the pending request |
| jam | output | 1 | Half-duplex back-pressure assert |

## Verification
The level comparison is combinational and feeds one register stage. Every result is therefore due one rising edge after its stimulus:
- a pause request appears one edge after the level change;
- a request drops one edge after the acknowledge;
- back pressure starts one edge after the frame or preamble pulse.

The bench drives all inputs on the falling edge and samples at the next falling edge, so each check lands exactly on the edge where its result is due. The back-pressure length is measured by counting the sampled cycles with `jam` high. Checks that something is ignored hold their stimulus for several cycles and look at `pause_req` and `jam` throughout.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_REQ_HI,
        PS_HELD,
        PS_REQ_ZERO
    } pause_st_e;

    localparam int EN_ANY  = 0;
    localparam int EN_ADDR = 1;
    localparam int EN_BC   = 2;
    localparam int EN_MC   = 3;

endpackage

// File: rtl/fc_level_cmp.sv
module fc_level_cmp #(
    parameter int LVL_W = 16
) (
    input  logic [LVL_W-1:0] fifo_bytes,
    input  logic [7:0]       hi_thr,
    input  logic [7:0]       lo_thr,
    output logic             at_hi,
    output logic             below_lo
);
    localparam int UW = (LVL_W - 6 > 8) ? LVL_W - 6 : 8;

    logic [UW-1:0] units_w;

    always_comb begin
        units_w  = UW'(fifo_bytes >> 6);
        at_hi    = units_w >= UW'(hi_thr);
        below_lo = units_w <  UW'(lo_thr);
    end
endmodule

// File: rtl/fc_pause_ctl.sv
module fc_pause_ctl
    import fc_pkg::*;
#(
    parameter int PT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fc_on,
    input  logic            at_hi,
    input  logic            below_lo,
    input  logic [PT_W-1:0] cfg_pause_time,
    input  logic            pause_ack,
    output logic            pause_req,
    output logic [PT_W-1:0] pause_time
);
    typedef struct packed {
        pause_st_e       st;
        logic            sent;
        logic [PT_W-1:0] ptime;
    } pst_t;

    pst_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (!fc_on) begin
            ps_d.st    = PS_IDLE;
            ps_d.sent  = 1'b0;
            ps_d.ptime = '0;
        end else begin
            unique case (ps_q.st)
                PS_IDLE: if (at_hi && !ps_q.sent) begin
                    ps_d.st    = PS_REQ_HI;
                    ps_d.ptime = cfg_pause_time;
                end
                PS_REQ_HI: if (pause_ack) begin
                    ps_d.st   = PS_HELD;
                    ps_d.sent = 1'b1;
                end
                PS_HELD: if (below_lo) begin
                    ps_d.st    = PS_REQ_ZERO;
                    ps_d.ptime = '0;
                end
                PS_REQ_ZERO: if (pause_ack) begin
                    ps_d.st   = PS_IDLE;
                    ps_d.sent = 1'b0;
                end
                default: ps_d.st = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '{st: PS_IDLE, sent: 1'b0, ptime: '0};
        else        ps_q <= ps_d;
    end

    assign pause_req  = (ps_q.st == PS_REQ_HI) || (ps_q.st == PS_REQ_ZERO);
    assign pause_time = ps_q.ptime;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_req && !pause_ack && fc_on) |=> pause_req);

    assert_zero_after_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_q.st == PS_HELD && below_lo && fc_on) |=> (pause_req && pause_time == '0));

    assert_off_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_on |=> (!pause_req && !ps_q.sent));
endmodule

// File: rtl/fc_jam_timer.sv
module fc_jam_timer
    import fc_pkg::*;
#(
    parameter int JAM_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       full_duplex,
    input  logic       at_hi,
    input  logic [3:0] cfg_en,
    input  logic [3:0] cfg_jam_code,
    input  logic       rx_preamble,
    input  logic       rx_frame_valid,
    input  logic       rx_addr_hit,
    input  logic       rx_bcast,
    input  logic       rx_mcast,
    output logic       jam
);
    localparam int CNT_W = $clog2(16 * JAM_UNIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } jst_t;

    jst_t js_d, js_q;
    logic class_hit, trig;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        class_hit = (cfg_en[EN_ADDR] && rx_addr_hit) ||
                    (cfg_en[EN_BC]   && rx_bcast)    ||
                    (cfg_en[EN_MC]   && rx_mcast);
        if (cfg_en[EN_ANY]) trig = rx_preamble && at_hi;
        else                trig = rx_frame_valid && class_hit && at_hi;
        load_val = CNT_W'((32'(cfg_jam_code) + 1) * JAM_UNIT);

        js_d = js_q;
        if (full_duplex)          js_d.cnt = '0;
        else if (trig)            js_d.cnt = load_val;
        else if (js_q.cnt != '0)  js_d.cnt = js_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) js_q <= '{cnt: '0};
        else        js_q <= js_d;
    end

    assign jam = js_q.cnt != '0;

    assert_no_jam_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex |=> !jam);

    assert_jam_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (js_q.cnt > 1 && !trig && !full_duplex) |=> (js_q.cnt == $past(js_q.cnt) - 1'b1));

    assert_no_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!jam && !at_hi) |=> !jam);
endmodule

// File: rtl/rx_flow_ctl.sv
module rx_flow_ctl
    import fc_pkg::*;
#(
    parameter int LVL_W    = 16,
    parameter int PT_W     = 16,
    parameter int JAM_UNIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_bytes,
    input  logic             full_duplex,
    input  logic [7:0]       cfg_hi_thr,
    input  logic [7:0]       cfg_lo_thr,
    input  logic [3:0]       cfg_jam_code,
    input  logic [3:0]       cfg_en,
    input  logic [PT_W-1:0]  cfg_pause_time,
    input  logic             rx_preamble,
    input  logic             rx_frame_valid,
    input  logic             rx_addr_hit,
    input  logic             rx_bcast,
    input  logic             rx_mcast,
    input  logic             pause_ack,
    output logic             pause_req,
    output logic [PT_W-1:0]  pause_time,
    output logic             jam
);
    logic at_hi, below_lo, fc_on;

    assign fc_on = full_duplex && cfg_en[EN_ANY];

    fc_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .fifo_bytes (fifo_bytes),
        .hi_thr     (cfg_hi_thr),
        .lo_thr     (cfg_lo_thr),
        .at_hi      (at_hi),
        .below_lo   (below_lo)
    );

    fc_pause_ctl #(.PT_W(PT_W)) u_pause (
        .clk            (clk),
        .rst_n          (rst_n),
        .fc_on          (fc_on),
        .at_hi          (at_hi),
        .below_lo       (below_lo),
        .cfg_pause_time (cfg_pause_time),
        .pause_ack      (pause_ack),
        .pause_req      (pause_req),
        .pause_time     (pause_time)
    );

    fc_jam_timer #(.JAM_UNIT(JAM_UNIT)) u_jam (
        .clk            (clk),
        .rst_n          (rst_n),
        .full_duplex    (full_duplex),
        .at_hi          (at_hi),
        .cfg_en         (cfg_en),
        .cfg_jam_code   (cfg_jam_code),
        .rx_preamble    (rx_preamble),
        .rx_frame_valid (rx_frame_valid),
        .rx_addr_hit    (rx_addr_hit),
        .rx_bcast       (rx_bcast),
        .rx_mcast       (rx_mcast),
        .jam            (jam)
    );

    assert_half_no_pause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !full_duplex |=> !pause_req);
endmodule

// File: tb/sim_rx_flow_ctl.sv
`timescale 1ns/1ps
module sim_rx_flow_ctl;
    localparam int UNIT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] fifo_bytes = '0;
    logic        full_duplex = 1'b1;
    logic [7:0]  cfg_hi_thr = 8'd4;
    logic [7:0]  cfg_lo_thr = 8'd2;
    logic [3:0]  cfg_jam_code = 4'd2;
    logic [3:0]  cfg_en = 4'b0001;
    logic [15:0] cfg_pause_time = 16'h1234;
    logic        rx_preamble = 1'b0, rx_frame_valid = 1'b0;
    logic        rx_addr_hit = 1'b0, rx_bcast = 1'b0, rx_mcast = 1'b0;
    logic        pause_ack = 1'b0;
    logic        pause_req;
    logic [15:0] pause_time;
    logic        jam;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rx_flow_ctl u0 (
        .clk(clk), .rst_n(rst_n), .fifo_bytes(fifo_bytes), .full_duplex(full_duplex),
        .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .cfg_jam_code(cfg_jam_code),
        .cfg_en(cfg_en), .cfg_pause_time(cfg_pause_time), .rx_preamble(rx_preamble),
        .rx_frame_valid(rx_frame_valid), .rx_addr_hit(rx_addr_hit), .rx_bcast(rx_bcast),
        .rx_mcast(rx_mcast), .pause_ack(pause_ack), .pause_req(pause_req),
        .pause_time(pause_time), .jam(jam)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_pulse();
        pause_ack = 1'b1;
        step(1);
        pause_ack = 1'b0;
    endtask

    task automatic hold_idle(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            step(1);
            chk(pause_req == 1'b0, tag, pause_req, 0);
            chk(jam == 1'b0, tag, jam, 0);
        end
    endtask

    task automatic count_jam(output int n);
        n = 0;
        step(1);
        while (jam && n < 400) begin
            n++;
            step(1);
        end
    endtask

    task automatic t_reset();
        step(1);
        chk(pause_req == 1'b0, "R1 pause_req", pause_req, 0);
        chk(jam == 1'b0, "R1 jam", jam, 0);
    endtask

    task automatic t_pause_once();
        full_duplex = 1'b1; cfg_en = 4'b0001;
        fifo_bytes = 16'd255;
        hold_idle("R2 below high", 3);
        fifo_bytes = 16'd300;
        step(1);
        chk(pause_req == 1'b1, "R3 req rise", pause_req, 1);
        chk(pause_time == 16'h1234, "R3 time", pause_time, 16'h1234);
        step(3);
        chk(pause_req == 1'b1, "R3 held", pause_req, 1);
        ack_pulse();
        chk(pause_req == 1'b0, "R3 ack drop", pause_req, 0);
        fifo_bytes = 16'd400;
        hold_idle("R4 single pause", 5);
        fifo_bytes = 16'd200;
        hold_idle("R2 above low", 2);
        fifo_bytes = 16'd100;
        step(1);
        chk(pause_req == 1'b1, "R5 zero req", pause_req, 1);
        chk(pause_time == 16'd0, "R5 zero time", pause_time, 0);
        ack_pulse();
        chk(pause_req == 1'b0, "R5 zero ack", pause_req, 0);
        fifo_bytes = 16'd0;
        hold_idle("R5 no repeat", 3);
    endtask

    task automatic t_fd_class();
        full_duplex = 1'b1; cfg_en = 4'b1110;
        fifo_bytes = 16'd400;
        rx_frame_valid = 1'b1; rx_bcast = 1'b1; rx_mcast = 1'b1; rx_addr_hit = 1'b1;
        rx_preamble = 1'b1;
        step(1);
        rx_frame_valid = 1'b0; rx_bcast = 1'b0; rx_mcast = 1'b0; rx_addr_hit = 1'b0;
        rx_preamble = 1'b0;
        chk(pause_req == 1'b0 && jam == 1'b0, "R6 class bits in full duplex", {pause_req, jam}, 0);
        hold_idle("R6 class bits in full duplex", 4);
        fifo_bytes = 16'd0;
        step(1);
    endtask

    task automatic t_disable();
        full_duplex = 1'b1; cfg_en = 4'b0001;
        fifo_bytes = 16'd400;
        step(1);
        chk(pause_req == 1'b1, "R10 setup req", pause_req, 1);
        ack_pulse();
        cfg_en = 4'b0000;
        step(1);
        cfg_en = 4'b0001; fifo_bytes = 16'd100;
        hold_idle("R10 sent flag cleared", 4);
        fifo_bytes = 16'd400;
        step(1);
        chk(pause_req == 1'b1, "R10 second req", pause_req, 1);
        cfg_en = 4'b0000;
        step(1);
        chk(pause_req == 1'b0, "R10 pending dropped", pause_req, 0);
        fifo_bytes = 16'd0;
        step(1);
    endtask

    task automatic t_hd_class();
        int n;
        full_duplex = 1'b0; cfg_en = 4'b0001; fifo_bytes = 16'd400;
        hold_idle("R11 no pause in half duplex", 3);
        cfg_en = 4'b0100; cfg_jam_code = 4'd2;
        rx_frame_valid = 1'b1; rx_bcast = 1'b1;
        step(1);
        rx_frame_valid = 1'b0; rx_bcast = 1'b0;
        chk(jam == 1'b1, "R7 jam start", jam, 1);
        n = 1;
        step(1);
        while (jam && n < 400) begin
            n++;
            step(1);
        end
        chk(n == 3 * UNIT, "R7 jam length", n, 3 * UNIT);
        chk(pause_req == 1'b0, "R11 no pause while jamming", pause_req, 0);
    endtask

    task automatic t_hd_nomatch();
        full_duplex = 1'b0; cfg_en = 4'b0100; fifo_bytes = 16'd400;
        rx_frame_valid = 1'b1; rx_mcast = 1'b1; rx_addr_hit = 1'b1;
        step(1);
        rx_frame_valid = 1'b0; rx_mcast = 1'b0; rx_addr_hit = 1'b0;
        chk(jam == 1'b0, "R9 class not enabled", jam, 0);
        hold_idle("R9 class not enabled", 3);
        fifo_bytes = 16'd200;
        rx_frame_valid = 1'b1; rx_bcast = 1'b1;
        step(1);
        rx_frame_valid = 1'b0; rx_bcast = 1'b0;
        chk(jam == 1'b0, "R9 level not high", jam, 0);
        hold_idle("R9 level not high", 3);
    endtask

    task automatic t_hd_any();
        int n;
        full_duplex = 1'b0; cfg_en = 4'b0101; cfg_jam_code = 4'd0; fifo_bytes = 16'd400;
        rx_frame_valid = 1'b1; rx_bcast = 1'b1;
        step(1);
        rx_frame_valid = 1'b0; rx_bcast = 1'b0;
        chk(jam == 1'b0, "R8 override of class bits", jam, 0);
        hold_idle("R8 override of class bits", 2);
        rx_preamble = 1'b1;
        step(1);
        rx_preamble = 1'b0;
        chk(jam == 1'b1, "R8 preamble start", jam, 1);
        n = 1;
        step(1);
        while (jam && n < 400) begin
            n++;
            step(1);
        end
        chk(n == UNIT, "R8 jam length", n, UNIT);
        full_duplex = 1'b1; cfg_en = 4'b0000; fifo_bytes = 16'd0;
        step(1);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        t_reset();
        t_pause_once();
        t_fd_class();
        t_disable();
        t_hd_class();
        t_hd_nomatch();
        t_hd_any();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule